// File: doc/BRIEF.md
# Prescaled Reload Down-Counter with Event Counter

This block keeps a reloadable down-counter that steps once for each cycle in which an external tick enable is high. The tick enable comes from a prescale clock divider whose nominal rate is 20 MHz. When the down-counter is already at zero and a tick arrives, it reloads from a programmable reload value. On that same tick a second counter, the event counter, advances by one. A reload value of zero makes the down-counter stay at zero, so the event counter then counts every tick.

Software reaches the three registers through a single write port that selects one target per cycle. All three values are driven out continuously for readback. Address decoding and tick generation sit outside the block.

Top module: `prescale_event_counter`

## Requirements
- R1: After reset, the reload value, down-counter and event counter all read zero.
- R2: On a cycle with tick_i high and a nonzero down-counter, the down-counter drops by one on the next clock edge. With tick_i low, the down-counter and the event counter keep their values.
- R3: On a cycle with tick_i high and the down-counter at zero, the down-counter takes the reload value and the event counter increases by one, both on the same edge.
- R4: With a reload value of 5 and a starting count of 7, successive ticks give down-counter values 7,6,5,4,3,2,1,0,5,4,3,2,1,0,5. The event counter rises by exactly two over that run.
- R5: With a reload value of 0, the down-counter stays at zero once it reaches zero, and the event counter increases on every tick after that.
- R6: A write with wr_en_i high replaces the selected register on the next edge. The wr_sel_i encoding is 0 for the reload value, 1 for the down-counter and 2 for the event counter. Counting continues from the written value.
- R7: If a write and a tick fall in the same cycle, the written value wins for the register being written. The other counter still takes the tick. The event counter increments when the down-counter was zero before the write.
- R8: The event counter wraps from 0xFFFFFFFF to 0 without saturating.
- R9: Writing the reload value leaves the down-counter untouched; the new value is used only at the next reload from zero. If a reload from zero happens in the same cycle as a write to the reload value, the down-counter loads the old reload value.
- R10: A write with wr_sel_i equal to 3 changes none of the three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescale tick enable, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 reload, 1 down-counter, 2 event counter, 3 none |
| wr_data_i | input | 32 | Write data |
| reload_o | output | 32 | Current reload value |
| down_o | output | 32 | Current down-counter value |
| events_o | output | 32 | Current event counter value |

## Verification
The hardest cases to reach from the ports are collisions within a single cycle. One is a tick that finds the down-counter at zero while software writes either the down-counter or the reload value. Random stimulus seldom lines these up, so the bench writes small values into the down-counter to make zeros frequent. It also steers directed cycles so that a write lands exactly on a wrap. The event counter's rollover is reached by writing 0xFFFFFFFF and then forcing a wrap, not by waiting for it.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_DOWN   = 2'd1,
        SEL_EVENT  = 2'd2,
        SEL_NONE   = 2'd3
    } wr_sel_e;

    localparam int unsigned NUM_TARGETS = 3;

endpackage

// File: rtl/pdc_reload_reg.sv
module pdc_reload_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] value_o
);
    typedef struct packed {
        logic [W-1:0] value;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.value = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_o = st_q.value;
endmodule

// File: rtl/pdc_down_ctr.sv
module pdc_down_ctr #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] count_o,
    output logic         wrap_o
);
    typedef struct packed {
        logic [W-1:0] count;
    } state_t;

    state_t st_d, st_q;
    logic   at_zero;

    assign at_zero = (st_q.count == '0);

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (at_zero) begin
                st_d.count = reload_i;
            end else begin
                st_d.count = st_q.count - W'(1);
            end
        end
        // software value overrides the tick for this register
        if (wr_i) begin
            st_d.count = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
    // wrap depends only on the pre-write count, so a write never hides it
    assign wrap_o  = tick_i & at_zero;
endmodule

// File: rtl/pdc_event_ctr.sv
module pdc_event_ctr #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         inc_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] count_o
);
    typedef struct packed {
        logic [W-1:0] count;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc_i) begin
            st_d.count = st_q.count + W'(1);
        end
        if (wr_i) begin
            st_d.count = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
endmodule

// File: rtl/prescale_event_counter.sv
module prescale_event_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         wr_en_i,
    input  logic [1:0]   wr_sel_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] reload_o,
    output logic [W-1:0] down_o,
    output logic [W-1:0] events_o
);
    import pdc_pkg::*;

    localparam int unsigned NT = NUM_TARGETS;

    logic [NT-1:0] wr_hit;
    logic          wrap;

    for (genvar g = 0; g < NT; g++) begin : g_dec
        assign wr_hit[g] = wr_en_i & (wr_sel_i == 2'(g));
    end

    pdc_reload_reg #(.W(W)) u_reload (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (wr_hit[SEL_RELOAD]),
        .wr_data_i (wr_data_i),
        .value_o   (reload_o)
    );

    pdc_down_ctr #(.W(W)) u_down (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .wr_i      (wr_hit[SEL_DOWN]),
        .wr_data_i (wr_data_i),
        .reload_i  (reload_o),
        .count_o   (down_o),
        .wrap_o    (wrap)
    );

    pdc_event_ctr #(.W(W)) u_event (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .inc_i     (wrap),
        .wr_i      (wr_hit[SEL_EVENT]),
        .wr_data_i (wr_data_i),
        .count_o   (events_o)
    );
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
    parameter int unsigned W = 32
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         tick_i,
    input logic         wr_en_i,
    input logic [1:0]   wr_sel_i,
    input logic [W-1:0] wr_data_i,
    input logic [W-1:0] reload_o,
    input logic [W-1:0] down_o,
    input logic [W-1:0] events_o
);
    logic wr_rel, wr_dn, wr_ev;
    assign wr_rel = wr_en_i && (wr_sel_i == 2'd0);
    assign wr_dn  = wr_en_i && (wr_sel_i == 2'd1);
    assign wr_ev  = wr_en_i && (wr_sel_i == 2'd2);

    AST_DOWN_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && down_o != '0 && !wr_dn) |=> down_o == $past(down_o) - W'(1)); // R2
    AST_DOWN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !wr_dn) |=> $stable(down_o)); // R2
    AST_RELOAD_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && down_o == '0 && !wr_dn) |=> down_o == $past(reload_o)); // R3
    AST_EVENT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && down_o == '0 && !wr_ev) |=> events_o == $past(events_o) + W'(1)); // R3
    AST_EVENT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!(tick_i && down_o == '0) && !wr_ev) |=> $stable(events_o)); // R7
    AST_WRITE_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_dn |=> down_o == $past(wr_data_i)); // R6
    AST_WRITE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_ev |=> events_o == $past(wr_data_i)); // R6
    AST_RELOAD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_rel |=> $stable(reload_o)); // R10
endmodule

bind prescale_event_counter pdc_checker #(.W(W)) u_pdc_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .reload_o  (reload_o),
    .down_o    (down_o),
    .events_o  (events_o)
);

// File: tb/prescale_event_counter_tb.sv
module prescale_event_counter_tb;
    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd3;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] reload_q, down_q, events_q;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    bit          finished = 1'b0;

    logic [W-1:0] m_rel = '0, m_down = '0, m_evt = '0;

    always #5 clk = ~clk;

    prescale_event_counter #(.W(W)) u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .reload_o  (reload_q),
        .down_o    (down_q),
        .events_o  (events_q)
    );

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
        end
    endtask

    // expected next state from the requirements
    task automatic model_step(input logic t, input logic we, input logic [1:0] sel,
                              input logic [W-1:0] d);
        logic         wrapped;
        logic [W-1:0] nd, ne, nr;
        wrapped = t && (m_down == '0);
        nd = m_down;
        if (t) nd = wrapped ? m_rel : m_down - 1;       // R2 R3
        ne = wrapped ? m_evt + 1 : m_evt;                // R3 R8
        nr = m_rel;
        if (we && sel == 2'd0) nr = d;                   // R9
        if (we && sel == 2'd1) nd = d;                   // R7
        if (we && sel == 2'd2) ne = d;
        m_rel = nr; m_down = nd; m_evt = ne;
    endtask

    task automatic step(input logic t, input logic we, input logic [1:0] sel,
                        input logic [W-1:0] d, input string tag);
        @(negedge clk);
        tick = t; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        model_step(t, we, sel, d);
        #1;
        check(tag, "reload", reload_q, m_rel);
        check(tag, "down", down_q, m_down);
        check(tag, "events", events_q, m_evt);
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] seq [15];
        logic [W-1:0] ev0;
        void'($urandom(32'd1234));
        seq = '{32'd7, 32'd6, 32'd5, 32'd4, 32'd3, 32'd2, 32'd1, 32'd0,
                32'd5, 32'd4, 32'd3, 32'd2, 32'd1, 32'd0, 32'd5};
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reload", reload_q, '0);
        check("R1", "down", down_q, '0);
        check("R1", "events", events_q, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 documented sequence
        step(1'b0, 1'b1, 2'd0, 32'd5, "R6");
        step(1'b0, 1'b1, 2'd1, 32'd7, "R6");
        ev0 = events_q;
        check("R4", "start", down_q, seq[0]);
        for (int i = 1; i < 15; i++) begin
            step(1'b1, 1'b0, 2'd3, '0, "R4");
            check("R4", "sequence", down_q, seq[i]);
        end
        check("R4", "event delta", events_q - ev0, 32'd2);

        // R2 no tick holds
        step(1'b0, 1'b0, 2'd3, '0, "R2");
        step(1'b0, 1'b0, 2'd3, '0, "R2");

        // R5 zero reload
        step(1'b0, 1'b1, 2'd0, 32'd0, "R5");
        step(1'b0, 1'b1, 2'd1, 32'd3, "R5");
        ev0 = events_q;
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 2'd3, '0, "R5");
        check("R5", "stuck", down_q, 32'd0);
        check("R5", "event delta", events_q - ev0, 32'd7);

        // R8 rollover
        step(1'b0, 1'b1, 2'd2, 32'hFFFF_FFFF, "R8");
        step(1'b1, 1'b0, 2'd3, '0, "R8");
        check("R8", "rollover", events_q, 32'd0);

        // R7 collisions: down at zero, write down with tick
        step(1'b0, 1'b1, 2'd0, 32'd9, "R7");
        ev0 = events_q;
        step(1'b1, 1'b1, 2'd1, 32'd4, "R7");
        check("R7", "down written", down_q, 32'd4);
        check("R7", "event ticked", events_q, ev0 + 1);
        step(1'b1, 1'b1, 2'd2, 32'd100, "R7");
        check("R7", "event written", events_q, 32'd100);
        check("R7", "down ticked", down_q, 32'd3);

        // R9 reload write does not disturb down; same-cycle wrap uses old value
        step(1'b0, 1'b1, 2'd1, 32'd6, "R9");
        step(1'b0, 1'b1, 2'd0, 32'd2, "R9");
        check("R9", "down untouched", down_q, 32'd6);
        step(1'b0, 1'b1, 2'd1, 32'd0, "R9");
        step(1'b1, 1'b1, 2'd0, 32'd8, "R9");
        check("R9", "old reload used", down_q, 32'd2);
        check("R9", "new reload held", reload_q, 32'd8);

        // R10 select 3
        step(1'b0, 1'b1, 2'd3, 32'hDEAD_BEEF, "R10");
        check("R10", "reload", reload_q, 32'd8);
        check("R10", "down", down_q, 32'd2);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic         t, we;
            logic [1:0]   s;
            logic [W-1:0] d;
            t  = ($urandom % 2) == 0;
            we = ($urandom % 8) == 0;
            s  = 2'($urandom % 4);
            case ($urandom % 8)
                0:       d = $urandom;
                1:       d = 32'hFFFF_FFFF;
                default: d = $urandom % 6;
            endcase
            step(t, we, s, d, "R6");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule